// File: doc/BRIEF.md
# Receive Character Buffer with Trigger Level and Time-Out

This block holds received serial characters between the receive shifter of an asynchronous serial port and the register port a processor reads. Each stored entry carries the data byte and three error bits: parity, framing and break. The oldest entry is always visible at the read port. A read strobe removes it.

The buffer's capacity is either 16 or 64 entries, chosen by a mode input. A two-bit code selects one of four trigger levels, and each capacity has its own set of four. A data-available request stays high while the fill count is at or above the chosen level. Some characters may remain below the trigger level with no more arriving. For that case a counter of character-time ticks raises a time-out flag, so the processor still learns about them.

An active-low ready output drives a DMA engine. It has two selectable policies: it follows occupancy, or it latches on the trigger or the time-out and releases only when the buffer is empty. A clear strobe empties the buffer. It does not touch the shift register that feeds the block.

Top module: `rx_char_buffer`

## Requirements
- R1: With `deep_mode`=0 the capacity is 16 entries, and with `deep_mode`=1 it is 64 entries. A write when the fill count equals the capacity is discarded, and `fill_count` is unchanged.
- R2: `trig_code` 0,1,2,3 selects a trigger level of 1,4,8,14 when `deep_mode`=0 and 1,16,32,56 when `deep_mode`=1. `avail_req` is high exactly while `fill_count` is at or above the level.
- R3: `data_ready` is high from the cycle after a character is accepted and stays high until the buffer is empty.
- R4: Entries leave in arrival order. `rd_data` and `rd_err` show the oldest entry, with `rd_err` bit 0 = parity, bit 1 = framing and bit 2 = break. A pulse on `rd_en` removes that entry. A read of an empty buffer has no effect.
- R5: `timeout_flag` sets on the fourth `char_tick` pulse counted while the buffer holds data. A `stop_mid` pulse or a read restarts the count. The flag never sets while the buffer is empty.
- R6: A read clears `timeout_flag` in the cycle after it.
- R7: With `dma_mode`=0, `rx_ready_n` is low exactly while `fill_count` is nonzero.
- R8: With `dma_mode`=1, `rx_ready_n` goes low when `avail_req` or `timeout_flag` is high. It then stays low until the buffer is empty, even if the count falls below the trigger level.
- R9: A `clr` pulse empties the buffer. It also clears `timeout_flag`, `overrun` and `err_present`.
- R10: A discarded write sets `overrun`, which stays high until `clr`.
- R11: `err_present` is high while any stored entry has a nonzero error field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Character-complete strobe from the receive shifter |
| wr_data | input | 8 | Received data byte |
| wr_err | input | 3 | Error bits of the character: parity, framing, break |
| stop_mid | input | 1 | Pulse at the middle of each received stop bit |
| rd_en | input | 1 | Read strobe from the register port |
| rd_data | output | 8 | Oldest stored data byte |
| rd_err | output | 3 | Error bits of the oldest entry |
| clr | input | 1 | Single-cycle clear strobe |
| deep_mode | input | 1 | 0 = 16 entries, 1 = 64 entries |
| trig_code | input | 2 | Trigger level select |
| dma_mode | input | 1 | Ready-output policy select |
| char_tick | input | 1 | One pulse per character time |
| fill_count | output | 7 | Number of stored entries |
| data_ready | output | 1 | At least one entry stored |
| avail_req | output | 1 | Fill count at or above trigger level |
| timeout_flag | output | 1 | Character time-out indication |
| rx_ready_n | output | 1 | Active-low DMA ready |
| overrun | output | 1 | Sticky discarded-write flag |
| err_present | output | 1 | Some stored entry carries an error |

## Verification
A wrong pointer or count inside the buffer shows up at the ports within one read. The byte or error bits at `rd_data` differ from the arrival order. `fill_count`, `data_ready` and `avail_req` disagree with the bench's own tally from the cycle after the faulty update. A time-out counter that is off by one moves the rise of `timeout_flag` by one `char_tick`, which a check that counts ticks catches. A DMA latch that releases early shows as `rx_ready_n` returning high while entries remain, once the count drops below the trigger level.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } entry_t;

  // trigger level for a given capacity mode and code
  function automatic int trig_level(input logic deep, input logic [1:0] code);
    int lvl;
    if (deep) begin
      case (code)
        2'd0: lvl = 1;
        2'd1: lvl = 16;
        2'd2: lvl = 32;
        default: lvl = 56;
      endcase
    end else begin
      case (code)
        2'd0: lvl = 1;
        2'd1: lvl = 4;
        2'd2: lvl = 8;
        default: lvl = 14;
      endcase
    end
    return lvl;
  endfunction

  function automatic int capacity(input logic deep, input int shallow, input int deepest);
    return deep ? deepest : shallow;
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH_MAX = 64,
  localparam int AW = $clog2(DEPTH_MAX),
  localparam int CW = $clog2(DEPTH_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  rxb_pkg::entry_t      wr_entry,
  input  logic                 rd_en,
  input  logic [CW-1:0]        cap,
  output rxb_pkg::entry_t      head,
  output logic [CW-1:0]        count,
  output logic                 push_ev,
  output logic                 pop_ev,
  output logic                 full,
  output logic                 overrun,
  output logic                 err_present
);
  rxb_pkg::entry_t mem [DEPTH_MAX];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] err_cnt;
  logic          push_err, pop_err;

  assign full     = !(count < cap);
  assign push_ev  = wr_en & !clr & !full;
  assign pop_ev   = rd_en & !clr & (count != '0);
  assign head     = mem[rptr];
  assign push_err = push_ev & (|wr_entry.err);
  assign pop_err  = pop_ev & (|head.err);
  assign err_present = (err_cnt != '0);

  always_ff @(posedge clk) begin
    if (push_ev) mem[wptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; err_cnt <= '0; overrun <= 1'b0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; count <= '0; err_cnt <= '0; overrun <= 1'b0;
    end else begin
      if (push_ev) wptr <= wptr + 1'b1;
      if (pop_ev)  rptr <= rptr + 1'b1;
      count   <= count + CW'(push_ev) - CW'(pop_ev);
      err_cnt <= err_cnt + CW'(push_err) - CW'(pop_err);
      if (wr_en && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rxb_timer.sv
module rxb_timer #(
  parameter int TO_CHARS = 4,
  localparam int TW = $clog2(TO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic restart,
  input  logic pop_ev,
  input  logic char_tick,
  input  logic nonempty,
  output logic timeout_flag
);
  logic [TW-1:0] tcnt;
  logic          fire;

  assign fire = nonempty & char_tick & !restart & (tcnt == TW'(TO_CHARS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0; timeout_flag <= 1'b0;
    end else if (clr) begin
      tcnt <= '0; timeout_flag <= 1'b0;
    end else begin
      if (restart || !nonempty) tcnt <= '0;
      else if (char_tick && tcnt != TW'(TO_CHARS)) tcnt <= tcnt + 1'b1;
      if (pop_ev)    timeout_flag <= 1'b0;
      else if (fire) timeout_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rxb_dma.sv
module rxb_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dma_mode,
  input  logic nonempty,
  input  logic avail_req,
  input  logic timeout_flag,
  output logic rx_ready_n
);
  logic latch_q, block_act;

  assign block_act  = nonempty & (latch_q | avail_req | timeout_flag);
  assign rx_ready_n = dma_mode ? !block_act : !nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= 1'b0;
    else if (clr)   latch_q <= 1'b0;
    else            latch_q <= block_act;
  end
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
  parameter int DEPTH_MAX = 64,
  parameter int SHALLOW   = 16,
  parameter int TO_CHARS  = 4,
  localparam int CW = $clog2(DEPTH_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [rxb_pkg::DATA_W-1:0] wr_data,
  input  logic [rxb_pkg::ERR_W-1:0]  wr_err,
  input  logic                       stop_mid,
  input  logic                       rd_en,
  output logic [rxb_pkg::DATA_W-1:0] rd_data,
  output logic [rxb_pkg::ERR_W-1:0]  rd_err,
  input  logic                       clr,
  input  logic                       deep_mode,
  input  logic [1:0]                 trig_code,
  input  logic                       dma_mode,
  input  logic                       char_tick,
  output logic [CW-1:0]              fill_count,
  output logic                       data_ready,
  output logic                       avail_req,
  output logic                       timeout_flag,
  output logic                       rx_ready_n,
  output logic                       overrun,
  output logic                       err_present
);
  rxb_pkg::entry_t wr_entry, head;
  logic [CW-1:0]   cap, trig;
  logic            push_ev, pop_ev, full;

  assign wr_entry = '{err: wr_err, data: wr_data};
  assign cap  = CW'(rxb_pkg::capacity(deep_mode, SHALLOW, DEPTH_MAX));
  assign trig = CW'(rxb_pkg::trig_level(deep_mode, trig_code));
  assign rd_data    = head.data;
  assign rd_err     = head.err;
  assign data_ready = (fill_count != '0);
  assign avail_req  = (fill_count >= trig);

  rxb_store #(.DEPTH_MAX(DEPTH_MAX)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_entry(wr_entry),
    .rd_en(rd_en), .cap(cap), .head(head), .count(fill_count),
    .push_ev(push_ev), .pop_ev(pop_ev), .full(full), .overrun(overrun),
    .err_present(err_present)
  );

  rxb_timer #(.TO_CHARS(TO_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .restart(stop_mid | pop_ev),
    .pop_ev(pop_ev), .char_tick(char_tick), .nonempty(data_ready),
    .timeout_flag(timeout_flag)
  );

  rxb_dma u_dma (
    .clk(clk), .rst_n(rst_n), .clr(clr), .dma_mode(dma_mode),
    .nonempty(data_ready), .avail_req(avail_req), .timeout_flag(timeout_flag),
    .rx_ready_n(rx_ready_n)
  );
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DEPTH_MAX = 64,
  localparam int CW = $clog2(DEPTH_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          clr,
  input logic          dma_mode,
  input logic [CW-1:0] fill_count,
  input logic          data_ready,
  input logic          avail_req,
  input logic          timeout_flag,
  input logic          rx_ready_n,
  input logic          overrun,
  input logic          err_present,
  input logic          push_ev,
  input logic          pop_ev,
  input logic          full
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH_MAX)); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clr) |=> overrun); // R10
  AST_DR_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> data_ready); // R3
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> (rx_ready_n && !timeout_flag && !err_present)); // R7
  AST_BLOCK_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && avail_req) |-> !rx_ready_n); // R8
  AST_TO_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> !timeout_flag); // R6
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_count == '0 && !overrun)); // R9
endmodule

bind rx_char_buffer rxb_checker #(.DEPTH_MAX(DEPTH_MAX)) u_chk (.*);

// File: tb/rx_char_buffer_test.sv
module rx_char_buffer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, stop_mid = 0, rd_en = 0, clr = 0, deep_mode = 0, dma_mode = 0, char_tick = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_err = 0;
  logic [1:0] trig_code = 0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [6:0] fill_count;
  logic data_ready, avail_req, timeout_flag, rx_ready_n, overrun, err_present;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_char_buffer uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk); wr_en = 1; wr_data = d; wr_err = e;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); char_tick = 1;
      @(negedge clk); char_tick = 0;
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic t_reset();
    chk("R3 reset data_ready", data_ready, 0);
    chk("R1 reset fill", fill_count, 0);
    chk("R7 reset rx_ready_n", rx_ready_n, 1);
    chk("R5 reset timeout", timeout_flag, 0);
    chk("R10 reset overrun", overrun, 0);
    chk("R11 reset err_present", err_present, 0);
  endtask

  task automatic t_order();
    do_clear();
    push(8'h11, 3'b000);
    chk("R3 data_ready after write", data_ready, 1);
    push(8'h22, 3'b010);
    push(8'h33, 3'b000);
    chk("R11 err_present with framing entry", err_present, 1);
    chk("R4 head data", rd_data, 8'h11);
    chk("R4 head err", rd_err, 0);
    pop();
    chk("R4 second data", rd_data, 8'h22);
    chk("R4 second err", rd_err, 3'b010);
    pop();
    chk("R11 err_present after error entry left", err_present, 0);
    chk("R4 third data", rd_data, 8'h33);
    pop();
    chk("R3 data_ready empty", data_ready, 0);
    pop();
    chk("R4 read of empty ignored", fill_count, 0);
    push(8'h44, 3'b100);
    chk("R4 pointer intact after empty read", rd_data, 8'h44);
    chk("R11 break entry", err_present, 1);
    do_clear();
    chk("R9 clear err_present", err_present, 0);
  endtask

  task automatic t_trigger();
    int lv;
    for (int dm = 0; dm < 2; dm++) begin
      for (int c = 0; c < 4; c++) begin
        deep_mode = dm[0]; trig_code = c[1:0];
        case (c)
          0: lv = 1;
          1: lv = (dm != 0) ? 16 : 4;
          2: lv = (dm != 0) ? 32 : 8;
          default: lv = (dm != 0) ? 56 : 14;
        endcase
        do_clear();
        for (int k = 0; k < lv - 1; k++) push(8'(k), 3'b000);
        chk($sformatf("R2 below level %0d", lv), avail_req, 0);
        push(8'hA5, 3'b000);
        chk($sformatf("R2 at level %0d", lv), avail_req, 1);
        push(8'hA6, 3'b000);
        chk($sformatf("R2 above level %0d", lv), avail_req, 1);
        pop(); pop();
        chk($sformatf("R2 back below level %0d", lv), avail_req, 0);
      end
    end
    do_clear();
  endtask

  task automatic t_full();
    deep_mode = 0; trig_code = 0;
    do_clear();
    for (int k = 0; k < 16; k++) push(8'(k + 8'h80), 3'b000);
    chk("R1 shallow full count", fill_count, 16);
    chk("R10 no overrun at full", overrun, 0);
    push(8'hEE, 3'b000);
    chk("R1 shallow write discarded", fill_count, 16);
    chk("R10 overrun set", overrun, 1);
    pop();
    chk("R10 overrun sticky after read", overrun, 1);
    chk("R4 order kept after drop", rd_data, 8'h81);
    do_clear();
    chk("R9 clear overrun", overrun, 0);
    chk("R9 clear fill", fill_count, 0);
    deep_mode = 1;
    for (int k = 0; k < 64; k++) push(8'(k), 3'b000);
    chk("R1 deep full count", fill_count, 64);
    push(8'hEE, 3'b000);
    chk("R1 deep write discarded", fill_count, 64);
    chk("R10 deep overrun", overrun, 1);
    deep_mode = 0;
    do_clear();
  endtask

  task automatic t_timeout();
    deep_mode = 0; trig_code = 2'd3;
    do_clear();
    tick(5);
    chk("R5 no timeout while empty", timeout_flag, 0);
    push(8'h5A, 3'b000);
    tick(3);
    chk("R5 three ticks", timeout_flag, 0);
    @(negedge clk); stop_mid = 1;
    @(negedge clk); stop_mid = 0;
    tick(3);
    chk("R5 restart by stop_mid", timeout_flag, 0);
    tick(1);
    chk("R5 fires on fourth tick", timeout_flag, 1);
    pop();
    chk("R6 read clears timeout", timeout_flag, 0);
    push(8'h01, 3'b000);
    push(8'h02, 3'b000);
    tick(3);
    pop();
    tick(3);
    chk("R5 restart by read", timeout_flag, 0);
    tick(1);
    chk("R5 fires after read restart", timeout_flag, 1);
    do_clear();
    chk("R9 clear timeout", timeout_flag, 0);
  endtask

  task automatic t_dma();
    deep_mode = 0; trig_code = 2'd1; dma_mode = 0;
    do_clear();
    push(8'h10, 3'b000);
    chk("R7 mode0 low with data", rx_ready_n, 0);
    pop();
    chk("R7 mode0 high when empty", rx_ready_n, 1);
    dma_mode = 1;
    push(8'h1, 0); push(8'h2, 0); push(8'h3, 0);
    chk("R8 mode1 high below trigger", rx_ready_n, 1);
    push(8'h4, 0);
    chk("R8 mode1 low at trigger", rx_ready_n, 0);
    pop(); pop(); pop();
    chk("R8 mode1 held below trigger", rx_ready_n, 0);
    pop();
    chk("R8 mode1 release at empty", rx_ready_n, 1);
    push(8'h9, 0);
    chk("R8 mode1 single char idle", rx_ready_n, 1);
    tick(4);
    chk("R8 mode1 low on timeout", rx_ready_n, 0);
    pop();
    chk("R8 mode1 release after timeout read", rx_ready_n, 1);
    dma_mode = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger();
    t_full();
    t_timeout();
    t_dma();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule